// File: doc/BRIEF.md
# Transmit FIFO Reset Sequencer

This block is a small transmit FIFO whose status flags (empty, half, full) can be taken through a qualified reset handshake. A reset starts only under three conditions at once: the active-low reset request is low, the active-low select-mode input is low, and the active-low transfer enable is high. Holding the enable low keeps the FIFO selected for data transfers, and while it is low the request has no effect. The three conditions must hold for a run of consecutive clock cycles. When the run completes, the FIFO shows a blocked Full state and refuses all traffic.

The block stays in that blocked state until the request or the select-mode input is sampled high. Either release empties the storage, and the flags then read Empty. The two releases differ in one way. A release through the request keeps the flag drivers enabled. A release through the select-mode input switches the flag drivers off, and they come back only when the FIFO is next selected with the enable.

In normal operation, Full asserts a fixed margin before true capacity, so a writer that reacts late can still place that many words. All logic runs on one clock and has one synchronous power-on reset.

Top module: `tx_fifo_rstseq`

## Requirements
- R1: After power-on reset, flag_empty=1, flag_half=0, flag_full=0, flags_oe=1 and rst_pending=0.
- R2: rst_pending and flag_full assert after the eighth consecutive clock edge at which rst_req_n=0, sel_mode_n=0 and en_n=1 are sampled together. After seven such edges neither is asserted.
- R3: While en_n=0 the reset request has no effect: rst_pending stays 0 and the flags keep following the FIFO level.
- R4: If the qualifying condition drops before the eighth edge, the sequencer returns to idle with the flags unchanged, and a later request needs eight fresh consecutive edges.
- R5: While rst_pending=1, flag_full=1, flag_empty=0 and flag_half=0, and both wr_ack and rd_ack are 0.
- R6: rst_pending stays 1 for as long as both rst_req_n and sel_mode_n are sampled 0, whatever en_n does.
- R7: When rst_req_n is sampled 1 while pending, the next cycle shows flag_empty=1, flag_half=0, flag_full=0, flags_oe=1, and all stored words are discarded.
- R8: When sel_mode_n is sampled 1 while rst_req_n is still 0 and a reset is pending, the FIFO empties and flags_oe goes 0. flags_oe returns to 1 after the first edge at which en_n is sampled 0. If both inputs are released at the same edge, the request path applies.
- R9: Outside a pending reset, flag_empty=1 when the level is 0, flag_half=1 when the level is at least DEPTH/2, and flag_full=1 when the level is at least DEPTH-8.
- R10: A write is accepted (wr_ack=1) when wr_req=1, en_n=0, no reset is pending and the level is below DEPTH. Exactly eight writes are therefore accepted after flag_full first asserts.
- R11: Reads return words in the order they were written. rd_ack=1 when rd_req=1, the level is non-zero and no reset is pending, and rd_data carries the head word in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| rst_req_n | input | 1 | FIFO reset request, active low |
| sel_mode_n | input | 1 | Select-mode input, active low |
| en_n | input | 1 | Transfer enable / FIFO select, active low |
| wr_req | input | 1 | Write request |
| wr_data | input | WIDTH | Write word |
| wr_ack | output | 1 | Write accepted this cycle |
| rd_req | input | 1 | Read request from the serializer side |
| rd_ack | output | 1 | Read accepted this cycle |
| rd_data | output | WIDTH | Head word |
| flag_empty | output | 1 | Empty flag |
| flag_half | output | 1 | Half flag |
| flag_full | output | 1 | Full flag (margin or pending reset) |
| flags_oe | output | 1 | Drive enable for the flag outputs |
| rst_pending | output | 1 | Reset qualified and waiting for release |

## Verification
Two pairs of events can land on the same clock edge. In the first, a pending reset is released while a write is attempted with the enable low. The write must be refused, and the FIFO must read Empty afterwards with no word stored. In the second, the select-mode release coincides with the enable being low: the drivers must go off on that edge and come back only at a later selection. Both pairs are provoked by directed steps and also arise from random bursts of reset requests mixed with random traffic. A bench model that tracks level, order, pending state and drive enable judges every cycle.

// File: rtl/tx_fifo_rstseq.sv
module tx_fifo_rstseq #(
  parameter int DEPTH       = 64,
  parameter int WIDTH       = 8,
  parameter int FULL_MARGIN = 8,
  parameter int QUAL_CYCLES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rst_req_n,
  input  logic             sel_mode_n,
  input  logic             en_n,
  input  logic             wr_req,
  input  logic [WIDTH-1:0] wr_data,
  output logic             wr_ack,
  input  logic             rd_req,
  output logic             rd_ack,
  output logic [WIDTH-1:0] rd_data,
  output logic             flag_empty,
  output logic             flag_half,
  output logic             flag_full,
  output logic             flags_oe,
  output logic             rst_pending
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;
  localparam int QW = $clog2(QUAL_CYCLES + 1);
  localparam logic [CW-1:0] CAP      = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_LVL = CW'(DEPTH / 2);
  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH - FULL_MARGIN);
  localparam logic [AW-1:0] LAST     = AW'(DEPTH - 1);
  localparam logic [QW-1:0] QLAST    = QW'(QUAL_CYCLES - 1);

  typedef enum logic [1:0] {S_IDLE, S_QUAL, S_HOLD} st_t;

  st_t              st;
  logic [QW-1:0]    qcnt;
  logic [AW-1:0]    wptr, rptr;
  logic [CW-1:0]    level;
  logic [WIDTH-1:0] mem [DEPTH];

  wire req_ok  = !rst_req_n && !sel_mode_n && en_n;
  wire hold    = (st == S_HOLD);
  wire rel_req = hold && rst_req_n;
  wire rel_sel = hold && !rst_req_n && sel_mode_n;
  wire release_now = rel_req || rel_sel;

  assign wr_ack      = wr_req && !en_n && !hold && (level != CAP);
  assign rd_ack      = rd_req && !hold && (level != '0);
  assign rd_data     = mem[rptr];
  assign rst_pending = hold;
  assign flag_full   = hold || (level >= FULL_LVL);
  assign flag_half   = !hold && (level >= HALF_LVL);
  assign flag_empty  = !hold && (level == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= S_IDLE;
      qcnt <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_ok) begin
          st   <= S_QUAL;
          qcnt <= QW'(1);
        end
        S_QUAL: if (!req_ok) begin
          st   <= S_IDLE;
          qcnt <= '0;
        end else if (qcnt == QLAST) begin
          st   <= S_HOLD;
          qcnt <= '0;
        end else begin
          qcnt <= qcnt + QW'(1);
        end
        S_HOLD: if (release_now) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || release_now) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (wr_ack) wptr <= (wptr == LAST) ? '0 : wptr + AW'(1);
      if (rd_ack) rptr <= (rptr == LAST) ? '0 : rptr + AW'(1);
      case ({wr_ack, rd_ack})
        2'b10:   level <= level + CW'(1);
        2'b01:   level <= level - CW'(1);
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ack) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst)          flags_oe <= 1'b1;
    else if (rel_sel) flags_oe <= 1'b0;
    else if (rel_req) flags_oe <= 1'b1;
    else if (!en_n)   flags_oe <= 1'b1;
  end
endmodule

module tx_fifo_rstseq_chk #(
  parameter int QUAL_CYCLES = 8
) (
  input logic clk,
  input logic rst,
  input logic rst_req_n,
  input logic sel_mode_n,
  input logic en_n,
  input logic wr_ack,
  input logic rd_ack,
  input logic flag_empty,
  input logic flag_half,
  input logic flag_full,
  input logic flags_oe,
  input logic rst_pending
);
  localparam int RW = $clog2(QUAL_CYCLES + 1);
  logic [RW-1:0] run;
  wire cond = !rst_req_n && !sel_mode_n && en_n;

  always_ff @(posedge clk) begin
    if (rst)                        run <= '0;
    else if (!cond)                 run <= '0;
    else if (run != RW'(QUAL_CYCLES)) run <= run + RW'(1);
  end

  assert_qualified_run_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_pending) |-> (run == RW'(QUAL_CYCLES)));

  assert_enable_blocks_R3: assert property (@(posedge clk) disable iff (rst)
    (!en_n && !rst_pending) |=> !rst_pending);

  assert_blocked_full_R5: assert property (@(posedge clk) disable iff (rst)
    rst_pending |-> (flag_full && !flag_empty && !flag_half && !wr_ack && !rd_ack));

  assert_hold_until_release_R6: assert property (@(posedge clk) disable iff (rst)
    (rst_pending && !rst_req_n && !sel_mode_n) |=> rst_pending);

  assert_req_release_empty_R7: assert property (@(posedge clk) disable iff (rst)
    (rst_pending && rst_req_n) |=> (flag_empty && !flag_half && !flag_full && flags_oe));

  assert_sel_release_undriven_R8: assert property (@(posedge clk) disable iff (rst)
    (rst_pending && !rst_req_n && sel_mode_n) |=> (!flags_oe && flag_empty));

  assert_no_read_when_empty_R11: assert property (@(posedge clk) disable iff (rst)
    flag_empty |-> !rd_ack);
endmodule

bind tx_fifo_rstseq tx_fifo_rstseq_chk #(.QUAL_CYCLES(QUAL_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .rst_req_n(rst_req_n), .sel_mode_n(sel_mode_n), .en_n(en_n),
  .wr_ack(wr_ack), .rd_ack(rd_ack), .flag_empty(flag_empty), .flag_half(flag_half),
  .flag_full(flag_full), .flags_oe(flags_oe), .rst_pending(rst_pending)
);

// File: tb/tx_fifo_rstseq_test.sv
module tx_fifo_rstseq_test;
  localparam int DEPTH = 64, WIDTH = 8, MARGIN = 8, QUAL = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rst_req_n = 1'b1, sel_mode_n = 1'b1, en_n = 1'b1;
  logic wr_req = 1'b0, rd_req = 1'b0;
  logic [WIDTH-1:0] wr_data = '0;
  logic wr_ack, rd_ack, flag_empty, flag_half, flag_full, flags_oe, rst_pending;
  logic [WIDTH-1:0] rd_data;

  always #2 clk = ~clk;

  tx_fifo_rstseq #(.DEPTH(DEPTH), .WIDTH(WIDTH), .FULL_MARGIN(MARGIN), .QUAL_CYCLES(QUAL)) uut (
    .clk(clk), .rst(rst), .rst_req_n(rst_req_n), .sel_mode_n(sel_mode_n), .en_n(en_n),
    .wr_req(wr_req), .wr_data(wr_data), .wr_ack(wr_ack), .rd_req(rd_req), .rd_ack(rd_ack),
    .rd_data(rd_data), .flag_empty(flag_empty), .flag_half(flag_half), .flag_full(flag_full),
    .flags_oe(flags_oe), .rst_pending(rst_pending));

  int total = 0, bad = 0;
  bit done = 0;
  int acc_wr = 0, post_full_wr = 0;

  logic [WIDTH-1:0] mq[$];
  bit mpend = 0, moe = 1;
  int mqc = 0;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit exp_empty(); return !mpend && mq.size() == 0; endfunction
  function automatic bit exp_half();  return !mpend && mq.size() >= DEPTH/2; endfunction
  function automatic bit exp_full();  return mpend || mq.size() >= DEPTH - MARGIN; endfunction

  task automatic step(input bit rq, input bit sl, input bit en, input bit w,
                      input logic [WIDTH-1:0] d, input bit r);
    bit cond, ewa, era;
    string t;
    rst_req_n = rq; sel_mode_n = sl; en_n = en; wr_req = w; wr_data = d; rd_req = r;
    #1;
    ewa = w && !en && !mpend && mq.size() < DEPTH;
    era = r && !mpend && mq.size() > 0;
    chk(mpend ? "R5" : "R10", "wr_ack", wr_ack, ewa);
    chk(mpend ? "R5" : "R11", "rd_ack", rd_ack, era);
    if (era) chk("R11", "rd_data", rd_data, mq[0]);
    if (wr_ack === 1'b1) begin
      acc_wr++;
      if (flag_full === 1'b1) post_full_wr++;
    end
    @(posedge clk);
    cond = !rq && !sl && en;
    if (mpend && (rq || sl)) begin
      mq.delete(); mpend = 0; moe = rq; mqc = 0;
    end else begin
      if (!mpend) begin
        if (cond) begin
          if (mqc == QUAL - 1) begin mpend = 1; mqc = 0; end
          else mqc++;
        end else mqc = 0;
      end
      if (era) void'(mq.pop_front());
      if (ewa) mq.push_back(d);
      if (!en) moe = 1;
    end
    @(negedge clk);
    t = mpend ? "R5" : "R9";
    chk(t, "flag_empty", flag_empty, exp_empty());
    chk(t, "flag_half", flag_half, exp_half());
    chk(t, "flag_full", flag_full, exp_full());
    chk(mpend ? "R2" : "R4", "rst_pending", rst_pending, mpend);
    chk("R8", "flags_oe", flags_oe, moe);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1, 1, 1, 0, '0, 0);
  endtask

  task automatic ask(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 1, 0, '0, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1", "flag_empty", flag_empty, 1);
    chk("R1", "flag_half", flag_half, 0);
    chk("R1", "flag_full", flag_full, 0);
    chk("R1", "flags_oe", flags_oe, 1);
    chk("R1", "rst_pending", rst_pending, 0);
    @(negedge clk);

    // fill past capacity, then drain in order
    acc_wr = 0; post_full_wr = 0;
    for (int k = 0; k < 70; k++) step(1, 1, 0, 1, WIDTH'(k * 7 + 3), 0);
    chk("R10", "writes accepted", acc_wr, DEPTH);
    chk("R10", "writes after full", post_full_wr, MARGIN);
    for (int k = 0; k < DEPTH; k++) step(1, 1, 1, 0, '0, 1);
    step(1, 1, 1, 0, '0, 1);
    chk("R11", "empty after drain", flag_empty, 1);

    // enable held low blocks the request
    for (int k = 0; k < 5; k++) step(1, 1, 0, 1, WIDTH'(k + 40), 0);
    for (int k = 0; k < 12; k++) step(0, 0, 0, 0, '0, 0);
    chk("R3", "rst_pending", rst_pending, 0);
    chk("R3", "flag_empty", flag_empty, 0);
    chk("R3", "flag_full", flag_full, 0);

    // cancelled request, then a full qualification
    ask(5);
    idle(1);
    chk("R4", "rst_pending after cancel", rst_pending, 0);
    chk("R4", "flag_empty after cancel", flag_empty, 0);
    ask(7);
    chk("R2", "full after seven", flag_full, 0);
    ask(1);
    chk("R2", "full after eight", flag_full, 1);

    // pending: traffic refused, hold regardless of enable
    step(0, 0, 0, 1, 8'hAA, 1);
    chk("R5", "flag_full", flag_full, 1);
    for (int k = 0; k < 20; k++) step(0, 0, k % 2, k % 3 == 0, 8'h55, 1);
    chk("R6", "still pending", rst_pending, 1);

    // release by request, colliding with a write attempt
    step(1, 0, 0, 1, 8'h77, 0);
    chk("R7", "flag_empty", flag_empty, 1);
    chk("R7", "flag_full", flag_full, 0);
    chk("R7", "flags_oe", flags_oe, 1);
    chk("R7", "rst_pending", rst_pending, 0);
    for (int k = 0; k < 3; k++) step(1, 1, 0, 1, WIDTH'(k + 90), 0);
    step(1, 1, 1, 0, '0, 1);

    // release by select-mode, with enable low on that edge
    ask(QUAL);
    step(0, 1, 0, 0, '0, 0);
    chk("R8", "flags_oe off", flags_oe, 0);
    chk("R8", "flag_empty", flag_empty, 1);
    idle(2);
    chk("R8", "flags_oe stays off", flags_oe, 0);
    step(1, 1, 0, 0, '0, 0);
    chk("R8", "flags_oe back", flags_oe, 1);

    // both released together: request path wins
    ask(QUAL);
    step(1, 1, 1, 0, '0, 0);
    chk("R8", "both released oe", flags_oe, 1);

    // random traffic with reset bursts
    for (int i = 0; i < 4000; i++) begin
      int p;
      p = int'($urandom % 100);
      if (p < 4) begin
        int len;
        len = 6 + int'($urandom % 6);
        for (int k = 0; k < len; k++) step(0, 0, 1, 0, '0, $urandom % 2);
        if ($urandom % 2) step(1, $urandom % 2, $urandom % 2, 1, WIDTH'($urandom), 0);
        else step(0, 1, $urandom % 2, 1, WIDTH'($urandom), 0);
      end else begin
        bit wbias;
        wbias = ((i / 300) % 2) == 0;
        step($urandom % 10 != 0, $urandom % 10 != 0, $urandom % 8 == 0,
             wbias ? ($urandom % 4 != 0) : ($urandom % 4 == 0),
             WIDTH'($urandom), wbias ? ($urandom % 4 == 0) : ($urandom % 4 != 0));
      end
    end
    finish_run();
  end
endmodule